// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one timer channel for a peripheral subsystem. A down-counter of `DATA_W` bits (32 by default) is advanced by a count-enable pulse, `tick_in`, after a prescaler that divides it by 1, 16 or 256. When the count falls from one to zero, a raw interrupt flag is set. Software reaches the channel through a plain synchronous register port: a byte address, a write strobe, write data, and read data that is formed combinationally from the address.

Three counting modes are selected in the control word. Free-running mode wraps to all-ones at the chosen width. Periodic mode reloads from the programmed reload value. One-shot mode halts at zero. There are two ways to program the reload value. One restarts the count at once. The other only changes what the next reload will use. The counter can also run in a narrow mode, in which only its low half (16 bits by default) counts.

Top module: `intv_timer`

## Requirements
- R1: After reset the control word reads 0x20, and the reload value, count, raw flag and `irq_out` are all zero.
- R2: Registers sit at byte offsets 0x00 (reload, restart), 0x04 (count), 0x08 (control, bits [7:0] read back zero-extended), 0x0C (interrupt clear), 0x10 (raw flag in bit 0), 0x14 (masked flag in bit 0) and 0x18 (reload, no restart). Offset 0x1C and any address with bits [1:0] not zero read 0 and ignore writes.
- R3: A write to 0x00 stores the reload value and loads the counter with the written data on the same edge. It takes precedence over a count step in that cycle.
- R4: A write to 0x18 stores the reload value and leaves the current count untouched. Reads of 0x00 and 0x18 both return the stored reload value.
- R5: Writes to the count register at 0x04 have no effect.
- R6: Control bit 7 enables counting. Control bits [3:2] select the prescale: 00 steps on every `tick_in` pulse, 01 on every 16th, 10 on every 256th, and 11 on every pulse. Nothing counts while bit 7 is clear.
- R7: Any write to the control register restarts the prescaler from zero.
- R8: A count step at value 1 leaves 0 and sets the raw flag on the same edge. The next step at 0 performs the mode's reload action.
- R9: Periodic mode (bit 6 = 1, bit 0 = 0) reloads the stored reload value.
- R10: Free-running mode (bits 6 and 0 both clear) reloads 0xFFFF in narrow mode or 0xFFFFFFFF in wide mode. It ignores the stored reload value.
- R11: One-shot mode (bit 0 = 1, whatever bit 6 holds) keeps the counter at zero until the next write to 0x00.
- R12: Control bit 1 = 0 selects narrow mode. In narrow mode only the low half decrements and is compared for expiry, the upper half holds its value, and count reads return the low half zero-extended.
- R13: Any write to 0x0C clears the raw flag. If an expiry falls in the same cycle, the flag stays set.
- R14: Control bit 5 is the interrupt enable. The masked flag and `irq_out` equal the raw flag ANDed with that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Count-enable pulse fed to the prescaler |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Level interrupt: raw flag AND enable |

## Verification
A clear written to 0x0C can land in the same cycle as an expiry step. The bench sets up this collision directly: it runs the count down to 1 and then issues the clear together with a `tick_in` pulse. It checks that the raw flag and `irq_out` are still set afterwards. A second collision, a reload-and-restart write arriving together with a count step, is exercised in the random phase. In that phase a bench model built from the requirements predicts every register read and `irq_out` after each cycle.

// File: rtl/intv_timer_pkg.sv
`timescale 1ns/1ps
package intv_timer_pkg;
   // control word bit positions (software-visible encoding)
   localparam int CB_ONCE   = 0;
   localparam int CB_WIDE   = 1;
   localparam int CB_DIV_LO = 2;
   localparam int CB_IE     = 5;
   localparam int CB_REPEAT = 6;
   localparam int CB_RUN    = 7;
   localparam int CTRL_W    = 8;
   localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

   // word index inside the register window
   typedef enum logic [2:0] {
      RG_LOAD   = 3'd0,
      RG_VALUE  = 3'd1,
      RG_CTRL   = 3'd2,
      RG_ICLR   = 3'd3,
      RG_RAW    = 3'd4,
      RG_MASKED = 3'd5,
      RG_BGLOAD = 3'd6,
      RG_NONE   = 3'd7
   } reg_sel_e;

   typedef enum logic [1:0] {
      MD_FREE     = 2'd0,
      MD_PERIODIC = 2'd1,
      MD_ONESHOT  = 2'd2
   } mode_e;

   typedef struct packed {
      logic wr_load;
      logic wr_bg;
      logic wr_ctrl;
      logic wr_clr;
      logic wr_val;
   } wr_strobe_t;
endpackage

// File: rtl/intv_timer_prescale.sv
`timescale 1ns/1ps
module intv_timer_prescale #(
   parameter int MID_LOG = 4,
   parameter int HI_LOG  = 8
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick_in,
   input  logic [1:0] div_sel,
   input  logic       restart,
   output logic       cnt_tick
);
   localparam int PRE_W = HI_LOG;

   initial begin
      assert (MID_LOG > 0 && MID_LOG < HI_LOG)
         else $error("prescale ratios must satisfy 0 < MID_LOG < HI_LOG");
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] term;

   always_comb begin
      case (div_sel)
         2'b01:   term = PRE_W'((1 << MID_LOG) - 1);
         2'b10:   term = {PRE_W{1'b1}};
         default: term = '0;
      endcase
   end

   assign cnt_tick = run & tick_in & (pre_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (restart) begin
         pre_q <= '0;
      end else if (run && tick_in) begin
         pre_q <= (pre_q == term) ? '0 : pre_q + 1'b1;
      end
   end

   assert_pre_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_q == '0));

   assert_pre_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !(run && tick_in)) |=> $stable(pre_q));
endmodule

// File: rtl/intv_timer_count.sv
`timescale 1ns/1ps
module intv_timer_count
   import intv_timer_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NARROW_EN = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              wr_load,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] reload_val,
   input  mode_e             mode,
   input  logic              wide,
   output logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] cnt_view,
   output logic              expire
);
   localparam int HALF_W = DATA_W / 2;

   initial begin
      assert (DATA_W >= 4 && (DATA_W % 2) == 0)
         else $error("DATA_W must be even and at least 4");
   end

   logic narrow;
   generate
      if (NARROW_EN != 0) begin : g_narrow
         assign narrow = ~wide;
      end else begin : g_wide_only
         assign narrow = 1'b0;
      end
   endgenerate

   logic              lo_zero, hi_zero, at_zero, at_one;
   logic [DATA_W-1:0] full_dec, cnt_dec, free_val, cnt_d;

   assign lo_zero  = (cnt_q[HALF_W-1:0] == '0);
   assign hi_zero  = (cnt_q[DATA_W-1:HALF_W] == '0);
   assign at_zero  = lo_zero & (narrow | hi_zero);
   assign at_one   = (cnt_q[HALF_W-1:0] == HALF_W'(1)) & (narrow | hi_zero);
   assign full_dec = cnt_q - 1'b1;
   assign cnt_dec  = narrow ? {cnt_q[DATA_W-1:HALF_W], full_dec[HALF_W-1:0]} : full_dec;
   assign free_val = narrow ? {cnt_q[DATA_W-1:HALF_W], {HALF_W{1'b1}}} : {DATA_W{1'b1}};
   assign cnt_view = narrow ? {{HALF_W{1'b0}}, cnt_q[HALF_W-1:0]} : cnt_q;

   always_comb begin
      cnt_d  = cnt_q;
      expire = 1'b0;
      if (wr_load) begin
         cnt_d = wdata;
      end else if (cnt_tick) begin
         if (at_zero) begin
            case (mode)
               MD_ONESHOT:  cnt_d = cnt_q;
               MD_PERIODIC: cnt_d = reload_val;
               default:     cnt_d = free_val;
            endcase
         end else begin
            cnt_d  = cnt_dec;
            expire = at_one;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assert_load_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> (cnt_q == $past(wdata)));

   assert_oneshot_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick && !wr_load && mode == MD_ONESHOT && at_zero) |=> $stable(cnt_q));

   assert_upper_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && !wr_load && !(cnt_tick && at_zero))
      |=> (cnt_q[DATA_W-1:HALF_W] == $past(cnt_q[DATA_W-1:HALF_W])));

   assert_expire_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt_q[HALF_W-1:0] == '0));

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick && !wr_load) |=> $stable(cnt_q));
endmodule

// File: rtl/intv_timer.sv
`timescale 1ns/1ps
module intv_timer
   import intv_timer_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int NARROW_EN   = 1,
   parameter int DIV_MID_LOG = 4,
   parameter int DIV_HI_LOG  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   localparam int SEL_LSB = 2;
   localparam int SEL_W   = 3;
   localparam int MAP_TOP = SEL_LSB + SEL_W;

   initial begin
      assert (ADDR_W >= MAP_TOP) else $error("ADDR_W too small for the register window");
      assert (DATA_W >= CTRL_W)  else $error("DATA_W narrower than the control word");
   end

   // ---------------- address decode ----------------
   logic in_range, acc_ok;
   generate
      if (ADDR_W > MAP_TOP) begin : g_upper
         assign in_range = ~|bus_addr[ADDR_W-1:MAP_TOP];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   reg_sel_e   sel;
   wr_strobe_t wr;
   assign acc_ok = in_range & (bus_addr[SEL_LSB-1:0] == '0);
   assign sel    = reg_sel_e'(bus_addr[MAP_TOP-1:SEL_LSB]);

   always_comb begin
      wr = '0;
      if (bus_we && acc_ok) begin
         case (sel)
            RG_LOAD:   wr.wr_load = 1'b1;
            RG_BGLOAD: wr.wr_bg   = 1'b1;
            RG_CTRL:   wr.wr_ctrl = 1'b1;
            RG_ICLR:   wr.wr_clr  = 1'b1;
            RG_VALUE:  wr.wr_val  = 1'b1;
            default:   ;
         endcase
      end
   end

   // ---------------- state ----------------
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] load_q;
   logic              raw_q;
   logic              cnt_tick, expire;
   logic [DATA_W-1:0] cnt_q, cnt_view;
   mode_e             mode;

   always_comb begin
      if (ctrl_q[CB_ONCE])        mode = MD_ONESHOT;
      else if (ctrl_q[CB_REPEAT]) mode = MD_PERIODIC;
      else                        mode = MD_FREE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         load_q <= '0;
         raw_q  <= 1'b0;
      end else begin
         if (wr.wr_ctrl)             ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (wr.wr_load || wr.wr_bg) load_q <= bus_wdata;
         if (expire)                 raw_q  <= 1'b1;
         else if (wr.wr_clr)         raw_q  <= 1'b0;
      end
   end

   intv_timer_prescale #(
      .MID_LOG (DIV_MID_LOG),
      .HI_LOG  (DIV_HI_LOG)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q[CB_RUN]),
      .tick_in  (tick_in),
      .div_sel  (ctrl_q[CB_DIV_LO+1:CB_DIV_LO]),
      .restart  (wr.wr_ctrl),
      .cnt_tick (cnt_tick)
   );

   intv_timer_count #(
      .DATA_W    (DATA_W),
      .NARROW_EN (NARROW_EN)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_tick   (cnt_tick),
      .wr_load    (wr.wr_load),
      .wdata      (bus_wdata),
      .reload_val (load_q),
      .mode       (mode),
      .wide       (ctrl_q[CB_WIDE]),
      .cnt_q      (cnt_q),
      .cnt_view   (cnt_view),
      .expire     (expire)
   );

   // ---------------- outputs ----------------
   assign irq_out = raw_q & ctrl_q[CB_IE];

   always_comb begin
      bus_rdata = '0;
      if (acc_ok) begin
         case (sel)
            RG_LOAD, RG_BGLOAD: bus_rdata = load_q;
            RG_VALUE:           bus_rdata = cnt_view;
            RG_CTRL:            bus_rdata = DATA_W'(ctrl_q);
            RG_RAW:             bus_rdata = DATA_W'(raw_q);
            RG_MASKED:          bus_rdata = DATA_W'(raw_q & ctrl_q[CB_IE]);
            default:            bus_rdata = '0;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_raw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw_q);

   assert_clr_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.wr_clr && !expire) |=> !raw_q);

   assert_irq_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q[CB_IE] && !wr.wr_ctrl) |=> irq_out);

   assert_bg_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.wr_bg && !cnt_tick) |=> $stable(cnt_q));

   assert_value_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.wr_val && !cnt_tick) |=> $stable(cnt_q));

   assert_ctrl_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr.wr_ctrl |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));
endmodule

// File: tb/intv_timer_test.sv
`timescale 1ns/1ps
module intv_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_in = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench model state
   logic [31:0] m_load, m_cnt;
   logic [7:0]  m_ctrl;
   logic        m_raw;
   int          m_pre;

   always #5 clk = ~clk;

   intv_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic logic [31:0] m_read(logic [4:0] a);
      if (a[1:0] != 2'b00) return 32'h0;
      case (a[4:2])
         3'd0, 3'd6: return m_load;
         3'd1:       return m_ctrl[1] ? m_cnt : {16'h0, m_cnt[15:0]};
         3'd2:       return {24'h0, m_ctrl};
         3'd4:       return {31'h0, m_raw};
         3'd5:       return {31'h0, m_raw & m_ctrl[5]};
         default:    return 32'h0;
      endcase
   endfunction

   task automatic model_step(bit we, logic [4:0] a, logic [31:0] d, bit tk);
      bit          ok = we && (a[1:0] == 2'b00);
      logic [2:0]  s = a[4:2];
      bit          narrow = !m_ctrl[1];
      logic [31:0] mask = narrow ? 32'h0000FFFF : 32'hFFFFFFFF;
      bit          ctick = 0;
      bit          expire = 0;
      int          div;
      case (m_ctrl[3:2])
         2'b01:   div = 16;
         2'b10:   div = 256;
         default: div = 1;
      endcase
      if (m_ctrl[7] && tk) begin
         if (m_pre == div - 1) begin ctick = 1; m_pre = 0; end
         else m_pre = m_pre + 1;
      end
      if (ok && s == 3'd2) m_pre = 0;
      if (ok && s == 3'd0) m_cnt = d;
      else if (ctick) begin
         if ((m_cnt & mask) == 32'h0) begin
            if (!m_ctrl[0]) begin
               if (m_ctrl[6]) m_cnt = m_load;
               else m_cnt = narrow ? {m_cnt[31:16], 16'hFFFF} : 32'hFFFFFFFF;
            end
         end else begin
            if ((m_cnt & mask) == 32'h1) expire = 1;
            m_cnt = narrow ? {m_cnt[31:16], m_cnt[15:0] - 16'd1} : m_cnt - 32'd1;
         end
      end
      if (expire) m_raw = 1'b1;
      else if (ok && s == 3'd3) m_raw = 1'b0;
      if (ok && (s == 3'd0 || s == 3'd6)) m_load = d;
      if (ok && s == 3'd2) m_ctrl = d[7:0];
   endtask

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
      end
   endtask

   task automatic cycle(bit we, logic [4:0] a, logic [31:0] d, bit tk);
      bus_we = we; bus_addr = a; bus_wdata = d; tick_in = tk;
      @(posedge clk);
      model_step(we, a, d, tk);
      @(negedge clk);
      bus_we = 1'b0; tick_in = 1'b0;
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      cycle(1'b1, a, d, 1'b0);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) cycle(1'b0, 5'h0, 32'h0, 1'b1);
   endtask

   // compare against the bench model
   task automatic peek(string req, logic [4:0] a);
      bus_addr = a; #1;
      chk(req, "rdata", bus_rdata, m_read(a));
      chk(req, "irq", {31'h0, irq_out}, {31'h0, m_raw & m_ctrl[5]});
   endtask

   // compare against a literal worked out from the requirements
   task automatic lit(string req, logic [4:0] a, logic [31:0] exp);
      bus_addr = a; #1;
      chk(req, "rdata", bus_rdata, exp);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R1: got timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4242));
      m_load = '0; m_cnt = '0; m_ctrl = 8'h20; m_raw = 1'b0; m_pre = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      lit("R1", 5'h08, 32'h20);
      lit("R1", 5'h00, 32'h0);
      lit("R1", 5'h04, 32'h0);
      lit("R1", 5'h10, 32'h0);
      chk("R1", "irq", {31'h0, irq_out}, 32'h0);

      // R3 / R4 / R2: load restarts, both reload offsets read back
      wr(5'h00, 32'd100);
      lit("R3", 5'h04, 32'd100);
      lit("R4", 5'h18, 32'd100);
      // R5 count writes ignored
      wr(5'h04, 32'd5);
      lit("R5", 5'h04, 32'd100);
      // R2 unused and misaligned accesses
      wr(5'h1C, 32'hFF);
      wr(5'h01, 32'h77);
      lit("R2", 5'h1C, 32'h0);
      lit("R2", 5'h00, 32'd100);
      lit("R2", 5'h08, 32'h20);

      // periodic, wide, div1, IE
      wr(5'h08, 32'hE2);
      wr(5'h00, 32'd3);
      ticks(2);
      lit("R8", 5'h04, 32'd1);
      lit("R8", 5'h10, 32'd0);
      ticks(1);
      lit("R8", 5'h04, 32'd0);
      lit("R8", 5'h10, 32'd1);
      lit("R14", 5'h14, 32'd1);
      chk("R14", "irq", {31'h0, irq_out}, 32'h1);
      ticks(1);
      lit("R9", 5'h04, 32'd3);

      // R13 clear colliding with expiry
      wr(5'h0C, 32'h0);
      lit("R13", 5'h10, 32'd0);
      ticks(2);
      cycle(1'b1, 5'h0C, 32'h0, 1'b1);
      lit("R13", 5'h04, 32'd0);
      lit("R13", 5'h10, 32'd1);
      wr(5'h0C, 32'hDEAD);
      lit("R13", 5'h10, 32'd0);

      // R14 masking
      ticks(4);
      wr(5'h08, 32'hC2);
      lit("R14", 5'h10, 32'd1);
      lit("R14", 5'h14, 32'd0);
      chk("R14", "irq", {31'h0, irq_out}, 32'h0);

      // R10 / R12 free-running narrow
      wr(5'h08, 32'h80);
      wr(5'h00, 32'hABCD0001);
      lit("R12", 5'h04, 32'h00000001);
      ticks(1);
      lit("R12", 5'h04, 32'h0);
      ticks(1);
      lit("R10", 5'h04, 32'h0000FFFF);
      ticks(1);
      lit("R10", 5'h04, 32'h0000FFFE);
      // free-running wide
      wr(5'h08, 32'h82);
      wr(5'h00, 32'd1);
      ticks(2);
      lit("R10", 5'h04, 32'hFFFFFFFF);

      // R12 narrow periodic keeps the upper half
      wr(5'h08, 32'hC0);
      wr(5'h00, 32'h00030002);
      lit("R12", 5'h04, 32'h2);
      ticks(3);
      lit("R12", 5'h04, 32'h2);
      wr(5'h08, 32'hC2);
      lit("R12", 5'h04, 32'h00030002);

      // R11 one-shot (bit 6 also set to show precedence)
      wr(5'h0C, 32'h0);
      wr(5'h08, 32'hE3);
      wr(5'h00, 32'd2);
      ticks(2);
      lit("R11", 5'h10, 32'd1);
      ticks(3);
      lit("R11", 5'h04, 32'd0);
      wr(5'h00, 32'd5);
      lit("R11", 5'h04, 32'd5);

      // R6 prescale ratios
      wr(5'h08, 32'hE6);
      wr(5'h00, 32'd100);
      ticks(15);
      lit("R6", 5'h04, 32'd100);
      ticks(1);
      lit("R6", 5'h04, 32'd99);
      wr(5'h08, 32'hEA);
      wr(5'h00, 32'd100);
      ticks(255);
      lit("R6", 5'h04, 32'd100);
      ticks(1);
      lit("R6", 5'h04, 32'd99);
      wr(5'h08, 32'hEE);
      ticks(1);
      lit("R6", 5'h04, 32'd98);
      wr(5'h08, 32'h6E);
      ticks(5);
      lit("R6", 5'h04, 32'd98);

      // R7 control write restarts the prescaler
      wr(5'h08, 32'hE6);
      ticks(10);
      wr(5'h08, 32'hE6);
      ticks(15);
      lit("R7", 5'h04, 32'd98);
      ticks(1);
      lit("R7", 5'h04, 32'd97);

      // R4 background reload
      wr(5'h08, 32'hE2);
      wr(5'h00, 32'd2);
      wr(5'h18, 32'd7);
      lit("R4", 5'h04, 32'd2);
      lit("R4", 5'h00, 32'd7);
      ticks(3);
      lit("R4", 5'h04, 32'd7);

      // random phase checked against the model
      for (int i = 0; i < 3000; i++) begin
         logic [2:0]  idx = 3'($urandom_range(0, 7));
         logic [31:0] d = $urandom;
         bit          we = ($urandom_range(0, 99) < 25);
         if (idx == 3'd0 || idx == 3'd6) d = 32'($urandom_range(0, 12));
         if (idx == 3'd2) begin
            d[7] = ($urandom_range(0, 9) < 8);
            d[3:2] = ($urandom_range(0, 9) == 0) ? 2'b01 : 2'b00;
         end
         cycle(we, {idx, 2'b00}, d, 1'($urandom_range(0, 1)));
         peek("R8", {3'($urandom_range(0, 7)), 2'b00});
      end

      summary();
   end
endmodule